// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block sequences the word addresses for one DMA channel that moves a strided rectangle of memory. Software supplies a start position in 32-bit word units. It also supplies the number of words in each line, the number of lines minus one, and the line pitch in words, which is the line size plus the gap between lines. It sets a direction bit and a burst-mode bit, then pulses start. The block issues one word address per accepted cycle on a request/ready memory port. It moves to the next line's base at each line end and signals completion after the last line.

A line length of zero selects ring mode. The channel then walks an area of pitch × (line count + 1) words without end and returns to the start position after the last word. It pulses one event at the end of the first half of the area and another at the end of the second half on every lap, so software can refill the two halves in turn. An abort input ends either mode at once. A readback port always shows the current position in word units.

Top module: `dma2d_agen`

## Requirements
- R1: While reset is held, and after it is released until the first start, busy_o, mem_req_o, done_o, half_o and lap_o are low and cur_addr_o is zero.
- R2: A start pulse while idle and without abort latches every configuration input. The direction output (1 = memory to device, 0 = device to memory) and the burst output (1 = 4-word bursts, 0 = single words) hold the latched values for the whole transfer. Changes to the configuration inputs and further start pulses during a transfer have no effect.
- R3: With a nonzero line length X, Y lines (line count input Y-1) and pitch P, the accepted addresses run start + y·P + x for y = 0..Y-1 and x = 0..X-1, line by line, modulo 2^AW.
- R4: An address is consumed only on a cycle with mem_req_o and mem_ready_i both high. While ready is low, the request stays high and the address stays unchanged.
- R5: In line mode, done_o is a one-cycle pulse in the cycle after the final accepted word. busy_o is low in that same cycle, and cur_addr_o then reads the final address plus one.
- R6: With line length zero, the accepted addresses run start + (n mod A), where A = P·(Y+1) ≥ 2 is even. The sequence does not end.
- R7: In ring mode, half_o pulses for one cycle after the word at offset A/2-1 is accepted, and lap_o pulses after the word at offset A-1, on every lap. half_o and lap_o never pulse in line mode, and done_o never pulses in ring mode.
- R8: While abort_i is high, mem_req_o is low in that same cycle. busy_o is low from the next cycle, no done, half or lap event follows, and cur_addr_o keeps the position of the next word that was not issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| abort_i | input | 1 | Abort, stops issue at once |
| cfg_addr_i | input | AW | Start position in word units |
| cfg_xlen_i | input | LW | Words per line, 0 selects ring mode |
| cfg_ylen_i | input | LW | Number of lines minus one |
| cfg_width_i | input | LW | Line pitch in words |
| cfg_dir_i | input | 1 | Direction, 1 memory to device |
| cfg_burst_i | input | 1 | 1 selects 4-word bursts |
| mem_req_o | output | 1 | Address request |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | AW | Word address of the request |
| mem_dir_o | output | 1 | Latched direction |
| mem_burst_o | output | 1 | Latched burst mode |
| cur_addr_o | output | AW | Readback of the current position |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Line-mode completion pulse |
| half_o | output | 1 | Ring mode first-half event |
| lap_o | output | 1 | Ring mode second-half event |

## Verification
A wrong line counter or line base register shows at the memory port on the first accepted word after a line end, because the address does not match start + y·P. A wrong ring counter shows as a half or lap pulse one cycle away from its expected accept, or as a missing return to the start position within one lap. A wrong busy flag or abort gate shows at once, as a request that continues after abort or after the final word, or as a done pulse that comes early or late by even one cycle.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic {
    MODE_LINES = 1'b0,
    MODE_RING  = 1'b1
  } agen_mode_e;
endpackage

// File: rtl/dma2d_line_ctr.sv
module dma2d_line_ctr #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic [LW-1:0] xlen_i,
  input  logic [LW-1:0] ylen_i,
  output logic          line_end_o,
  output logic          last_line_o
);
  logic [LW-1:0] x_q, x_d, y_q, y_d;
  logic          en;

  assign line_end_o  = (x_q == xlen_i - LW'(1));
  assign last_line_o = (y_q == ylen_i);
  assign en          = clear_i | step_i;

  always_comb begin
    x_d = x_q;
    y_d = y_q;
    if (clear_i) begin
      x_d = '0;
      y_d = '0;
    end else if (line_end_o) begin
      x_d = '0;
      y_d = y_q + LW'(1);
    end else begin
      x_d = x_q + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (en) begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end
endmodule

// File: rtl/dma2d_ring_ctr.sv
module dma2d_ring_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic [CW-1:0] area_i,
  output logic          half_hit_o,
  output logic          lap_hit_o
);
  logic [CW-1:0] pos_q, pos_d;
  logic          en;

  assign half_hit_o = (pos_q == (area_i >> 1) - CW'(1));
  assign lap_hit_o  = (pos_q == area_i - CW'(1));
  assign en         = clear_i | step_i;

  always_comb begin
    pos_d = pos_q + CW'(1);
    if (clear_i || lap_hit_o) pos_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  pos_q <= '0;
    else if (en) pos_q <= pos_d;
  end
endmodule

// File: rtl/dma2d_addr_reg.sv
module dma2d_addr_reg #(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          step_i,
  input  logic          line_jump_i,
  input  logic          wrap_home_i,
  input  logic [LW-1:0] pitch_i,
  output logic [AW-1:0] cur_o
);
  logic [AW-1:0] cur_q, cur_d, base_q, base_d, home_q, home_d;
  logic [AW-1:0] next_base;
  logic          en;

  assign next_base = base_q + AW'(pitch_i);
  assign en        = load_i | step_i;
  assign cur_o     = cur_q;

  always_comb begin
    cur_d  = cur_q + AW'(1);
    base_d = base_q;
    home_d = home_q;
    if (load_i) begin
      cur_d  = load_addr_i;
      base_d = load_addr_i;
      home_d = load_addr_i;
    end else if (wrap_home_i) begin
      cur_d = home_q;
    end else if (line_jump_i) begin
      cur_d  = next_base;
      base_d = next_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      base_q <= '0;
      home_q <= '0;
    end else if (en) begin
      cur_q  <= cur_d;
      base_q <= base_d;
      home_q <= home_d;
    end
  end
endmodule

// File: rtl/dma2d_agen.sv
module dma2d_agen
  import dma2d_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [LW-1:0] cfg_xlen_i,
  input  logic [LW-1:0] cfg_ylen_i,
  input  logic [LW-1:0] cfg_width_i,
  input  logic          cfg_dir_i,
  input  logic          cfg_burst_i,
  output logic          mem_req_o,
  input  logic          mem_ready_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_dir_o,
  output logic          mem_burst_o,
  output logic [AW-1:0] cur_addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          half_o,
  output logic          lap_o
);
  localparam int CW = 2 * LW;

  logic [1:0]    rs_q;
  logic          rst_int_n;
  logic [LW-1:0] xlen_q, ylen_q, width_q;
  logic          dir_q, burst_q;
  agen_mode_e    mode_q, mode_d;
  logic [CW-1:0] area_q, area_d;
  logic          busy_q, busy_d, done_q, done_d, half_q, half_d, lap_q, lap_d;
  logic          start_ok, accept, ring, finish;
  logic          line_end, last_line, half_hit, lap_hit;
  logic [AW-1:0] cur_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  assign start_ok  = start_i & ~busy_q & ~abort_i;
  assign mem_req_o = busy_q & ~abort_i;
  assign accept    = mem_req_o & mem_ready_i;
  assign ring      = (mode_q == MODE_RING);
  assign finish    = accept & ~ring & line_end & last_line;

  assign mode_d = (cfg_xlen_i == '0) ? MODE_RING : MODE_LINES;
  assign area_d = CW'(cfg_width_i) * (CW'(cfg_ylen_i) + CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xlen_q  <= '0;
      ylen_q  <= '0;
      width_q <= '0;
      dir_q   <= 1'b0;
      burst_q <= 1'b0;
      mode_q  <= MODE_LINES;
      area_q  <= '0;
    end else if (!rst_int_n) begin
      mode_q  <= MODE_LINES;
    end else if (start_ok) begin
      xlen_q  <= cfg_xlen_i;
      ylen_q  <= cfg_ylen_i;
      width_q <= cfg_width_i;
      dir_q   <= cfg_dir_i;
      burst_q <= cfg_burst_i;
      mode_q  <= mode_d;
      area_q  <= area_d;
    end
  end

  always_comb begin
    busy_d = busy_q;
    if (start_ok)                 busy_d = 1'b1;
    else if (abort_i || finish)   busy_d = 1'b0;
    done_d = finish;
    half_d = accept & ring & half_hit;
    lap_d  = accept & ring & lap_hit;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      half_q <= 1'b0;
      lap_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      half_q <= half_d;
      lap_q  <= lap_d;
    end
  end

  dma2d_line_ctr #(.LW(LW)) line_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clear_i    (start_ok),
    .step_i     (accept & ~ring),
    .xlen_i     (xlen_q),
    .ylen_i     (ylen_q),
    .line_end_o (line_end),
    .last_line_o(last_line)
  );

  dma2d_ring_ctr #(.CW(CW)) ring_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clear_i   (start_ok),
    .step_i    (accept & ring),
    .area_i    (area_q),
    .half_hit_o(half_hit),
    .lap_hit_o (lap_hit)
  );

  dma2d_addr_reg #(.AW(AW), .LW(LW)) addr_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (start_ok),
    .load_addr_i(cfg_addr_i),
    .step_i     (accept),
    .line_jump_i(~ring & line_end & ~last_line),
    .wrap_home_i(ring & lap_hit),
    .pitch_i    (width_q),
    .cur_o      (cur_addr)
  );

  assign mem_addr_o  = cur_addr;
  assign cur_addr_o  = cur_addr;
  assign mem_dir_o   = dir_q;
  assign mem_burst_o = burst_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign half_o      = half_q;
  assign lap_o       = lap_q;
endmodule

// File: rtl/dma2d_agen_chk.sv
module dma2d_agen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          abort_i,
  input logic          mem_req_o,
  input logic          mem_ready_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          half_o,
  input logic          lap_o
);
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> $stable(mem_addr_o));

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_event_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, half_o, lap_o}));

  p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!busy_o && !done_o && !half_o && !lap_o));
endmodule

bind dma2d_agen dma2d_agen_chk #(.AW(AW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .abort_i    (abort_i),
  .mem_req_o  (mem_req_o),
  .mem_ready_i(mem_ready_i),
  .mem_addr_o (mem_addr_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .half_o     (half_o),
  .lap_o      (lap_o)
);

// File: tb/dma2d_agen_tb_top.sv
module dma2d_agen_tb_top;
  localparam int AW = 16;
  localparam int LW = 8;

  logic          clk, rst_n, start_i, abort_i, cfg_dir_i, cfg_burst_i, mem_ready_i;
  logic [AW-1:0] cfg_addr_i;
  logic [LW-1:0] cfg_xlen_i, cfg_ylen_i, cfg_width_i;
  logic          mem_req_o, mem_dir_o, mem_burst_o, busy_o, done_o, half_o, lap_o;
  logic [AW-1:0] mem_addr_o, cur_addr_o;

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;

  // start(16) xlen(8) ylen(8) pitch(8) ready mask(8)
  localparam logic [47:0] VEC [4] = '{
    {16'h0100, 8'd4, 8'd2, 8'd6, 8'hFF},
    {16'h0200, 8'd3, 8'd3, 8'd3, 8'hA5},
    {16'hFFFC, 8'd2, 8'd1, 8'd5, 8'hFF},
    {16'h0040, 8'd1, 8'd0, 8'd1, 8'h3C}
  };

  dma2d_agen #(.AW(AW), .LW(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .cfg_addr_i(cfg_addr_i), .cfg_xlen_i(cfg_xlen_i), .cfg_ylen_i(cfg_ylen_i),
    .cfg_width_i(cfg_width_i), .cfg_dir_i(cfg_dir_i), .cfg_burst_i(cfg_burst_i),
    .mem_req_o(mem_req_o), .mem_ready_i(mem_ready_i), .mem_addr_o(mem_addr_o),
    .mem_dir_o(mem_dir_o), .mem_burst_o(mem_burst_o), .cur_addr_o(cur_addr_o),
    .busy_o(busy_o), .done_o(done_o), .half_o(half_o), .lap_o(lap_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic begin_xfer(input logic [AW-1:0] a, input logic [LW-1:0] x,
                            input logic [LW-1:0] y, input logic [LW-1:0] w,
                            input logic d, input logic b);
    @(negedge clk);
    cfg_addr_i = a; cfg_xlen_i = x; cfg_ylen_i = y; cfg_width_i = w;
    cfg_dir_i = d; cfg_burst_i = b; start_i = 1'b1;
  endtask

  task automatic run_lines(input logic [47:0] v, input logic d, input logic b);
    logic [AW-1:0] st, exp, base, last;
    logic [LW-1:0] xl, yl, w;
    logic [7:0]    mask;
    int            n, tot, cyc, x;
    logic          rdy;
    st = v[47:32]; xl = v[31:24]; yl = v[23:16]; w = v[15:8]; mask = v[7:0];
    tot = int'(xl) * (int'(yl) + 1);
    exp = st; base = st; last = st; n = 0; cyc = 0; x = 0;
    begin_xfer(st, xl, yl, w, d, b);
    while (n < tot && cyc < 4000) begin
      @(negedge clk);
      start_i = 1'b0;
      if (cyc == 1 && tot >= 4) begin
        cfg_xlen_i = 8'd0; cfg_width_i = 8'd9; cfg_addr_i = 16'h7777;
        cfg_dir_i = ~d; cfg_burst_i = ~b; start_i = 1'b1;
      end
      rdy = mask[cyc % 8];
      mem_ready_i = rdy;
      #1;
      chk("R5 busy during transfer", busy_o, 1'b1);
      chk("R5 no early done", done_o, 1'b0);
      chk("R7 no ring events in line mode", {half_o, lap_o}, 2'b00);
      chk("R4 request held", mem_req_o, 1'b1);
      if (mem_req_o && rdy) begin
        chk("R3 address", mem_addr_o, exp);
        chk("R2 direction and burst", {mem_dir_o, mem_burst_o}, {d, b});
        last = exp; n++;
        if (x == int'(xl) - 1) begin
          x = 0; base = base + AW'(w); exp = base;
        end else begin
          x++; exp = exp + 1'b1;
        end
      end
      cyc++;
    end
    @(negedge clk);
    start_i = 1'b0; mem_ready_i = 1'b0;
    #1;
    chk("R5 done pulse", done_o, 1'b1);
    chk("R5 idle at done", busy_o, 1'b0);
    chk("R5 readback after done", cur_addr_o, last + 1'b1);
    @(negedge clk);
    #1;
    chk("R5 done one cycle", done_o, 1'b0);
    chk("R5 no request after done", mem_req_o, 1'b0);
  endtask

  initial begin
    logic [AW-1:0] rst0;
    int            n, cyc, pos, prev;
    logic          rdy;
    logic [7:0]    mask;
    rst_n = 1'b0; start_i = 1'b0; abort_i = 1'b0; mem_ready_i = 1'b0;
    cfg_addr_i = '0; cfg_xlen_i = '0; cfg_ylen_i = '0; cfg_width_i = '0;
    cfg_dir_i = 1'b0; cfg_burst_i = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset outputs", {busy_o, mem_req_o, done_o, half_o, lap_o}, 5'b0);
    chk("R1 reset readback", cur_addr_o, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 idle after release", {busy_o, mem_req_o, done_o, half_o, lap_o}, 5'b0);
    rst0 = cur_addr_o;
    chk("R1 readback after release", rst0, '0);

    for (int i = 0; i < 4; i++) begin
      run_lines(VEC[i], i[0], i[1]);
    end

    // R8: abort in line mode after three words
    begin_xfer(16'h0500, 8'd4, 8'd2, 8'd6, 1'b0, 1'b0);
    @(negedge clk); start_i = 1'b0; mem_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    abort_i = 1'b1;
    #1;
    chk("R8 request drops with abort", mem_req_o, 1'b0);
    @(negedge clk);
    abort_i = 1'b0;
    #1;
    chk("R8 busy low after abort", busy_o, 1'b0);
    chk("R8 readback holds position", cur_addr_o, 16'h0503);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R8 no events after abort", {done_o, half_o, lap_o, mem_req_o}, 4'b0);
    end

    // R6/R7: ring mode, pitch 2, 4 lines, area 8
    begin_xfer(16'h0300, 8'd0, 8'd3, 8'd2, 1'b1, 1'b0);
    mask = 8'hDB; n = 0; cyc = 0; prev = -1;
    while (n < 20 && cyc < 4000) begin
      @(negedge clk);
      start_i = 1'b0;
      rdy = mask[cyc % 8];
      mem_ready_i = rdy;
      #1;
      chk("R7 half event", half_o, (prev == 3));
      chk("R7 lap event", lap_o, (prev == 7));
      chk("R7 no done in ring mode", done_o, 1'b0);
      prev = -1;
      if (mem_req_o && rdy) begin
        pos = n % 8;
        chk("R6 ring address", mem_addr_o, 16'h0300 + pos[15:0]);
        prev = pos; n++;
      end
      cyc++;
    end
    @(negedge clk);
    mem_ready_i = 1'b0;
    #1;
    chk("R7 half event last", half_o, (prev == 3));
    chk("R7 lap event last", lap_o, (prev == 7));
    chk("R6 still running", busy_o, 1'b1);
    abort_i = 1'b1;
    #1;
    chk("R8 ring request drops", mem_req_o, 1'b0);
    @(negedge clk);
    abort_i = 1'b0;
    #1;
    chk("R8 ring idle after abort", {busy_o, done_o, half_o, lap_o}, 4'b0);
    chk("R8 ring readback", cur_addr_o, 16'h0300 + 16'(n % 8));

    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule